// File: doc/BRIEF.md
# SMBus Register Access Sequencer

This block lives behind a byte-level SMBus slave front end and turns a series of SMBus transactions into a single internal configuration or memory access. The front end delivers, one at a time, every byte the master sends. Address bytes are flagged as such. The front end also reports each stop condition and asks for each byte the slave must return. Each transaction opens with a command byte. That byte says whether it begins or ends a sequence, which address space is targeted, which internal operation is wanted, how long the payload is, and whether a PEC byte follows.

Several write transactions, split in any way, fill a fixed list of eight field positions: the target address bytes, then the write data. The transaction flagged as the last one starts the internal access on a request/response port. A read is done in two stages. A write sequence carrying the read opcode starts the internal read. A read sequence then streams back a status byte and the four captured data bytes. A transaction with a bad PEC byte or a reserved length class is dropped whole and is reported through the status byte.

Top module: `smbseq_top`

## Requirements
- R1: The command byte is decoded as follows. Bit 7 (Begin) restarts field collection and the read position. Bit 6 (End) closes a sequence. Bit 5 selects memory space (1) or configuration space (0). Bit 4 enables PEC. Bits 3:2 give the operation: 00 read dword, 01 write byte, 10 write word, 11 write dword. Bits 1:0 give the length class: 00 one byte, 01 two bytes, 10 a count byte followed by that many bytes, 11 reserved.
- R2: Payload data bytes fill positions 0 to 7 in arrival order, continuing across the transactions of a sequence. The positions hold: 0 bus, 1 device/function, 2 register high (low nibble), 3 register low, then 4 to 7 the write data, least significant byte first. Bytes beyond position 7 are dropped.
- R3: A valid write transaction carrying End raises reqValid at the clock edge after its stop. reqValid and the request fields then hold steady until reqReady. Transactions without End start nothing.
- R4: A configuration access presents reqAddr = {4'h0, bus, devfn, reg[11:0]}. A memory access presents reqAddr = {pos0, pos1, pos2, pos3}. reqData = {pos7, pos6, pos5, pos4}. reqWrite is 0 only for the read dword operation.
- R5: A word access clears reqAddr[0]. A dword access (read or write) clears reqAddr[1:0]. A byte access keeps every address bit.
- R6: The PEC is CRC-8 with polynomial 0x07 and initial value 0. It covers every byte of the transaction, starting with the address byte. On writes, a PEC byte that does not match causes the transaction to be dropped.
- R7: A transaction with length class 11, or with a payload length that differs from its class, is dropped, and no access is started.
- R8: A dropped transaction leaves the collected fields and their fill position as they were before it. It also sets the error bit.
- R9: After a read address byte (LSB 1), the block sends the following. For class 10, it first sends a count equal to the number of response bytes left. It then sends response bytes from the current position: status, then data[7:0], [15:8], [23:16], [31:24]. When PEC is enabled, the CRC byte follows. The position carries across transactions. Bytes past the end read 0xFF.
- R10: In the status byte, bit 0 is a sticky error flag, cleared when the status byte is sent. Bit 1 is set from launch until rspValid. All other bits are 0.
- R11: For a read access, rspData is captured on rspValid and returned in later read sequences.
- R12: A valid End write that arrives while an access is still pending starts nothing and sets the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | A byte sent by the master is present |
| rxAddr | input | 1 | The present byte is an address byte (after a start or repeated start) |
| rxByte | input | 8 | Byte sent by the master |
| rxStop | input | 1 | One-cycle pulse at the end of a transaction |
| txReq | input | 1 | The master takes the byte on txByte |
| txByte | output | 8 | Next byte to return to the master |
| reqValid | output | 1 | Internal access request |
| reqReady | input | 1 | Request accepted |
| reqWrite | output | 1 | 1 for a write access |
| reqMem | output | 1 | 1 for memory space, 0 for configuration |
| reqOp | output | 2 | Operation code from the command byte |
| reqAddr | output | 32 | Aligned access address |
| reqData | output | 32 | Write data |
| rspValid | input | 1 | One-cycle pulse when the access completes |
| rspData | input | 32 | Read result |

## Verification
The assertions assume a well-behaved front end and responder. rxValid and rxStop never occur in the same cycle. txReq is only asserted after a read address byte. reqReady is raised only against a pending request, and rspValid follows only after that acceptance. The bench drives every byte through one task that leaves an idle cycle after each byte, a stop pulse and a settling gap. It pulls response bytes through a separate task that is used only after a read address byte. A single responder loop acknowledges a request, then answers one cycle later, and can be paused to hold an access pending.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;
  localparam int FIELD_CNT  = 8;
  localparam int IDX_W      = $clog2(FIELD_CNT);
  localparam int POS_W      = $clog2(FIELD_CNT + 1);
  localparam int DATA_BYTES = 4;
  localparam int RD_LEN     = DATA_BYTES + 1;
  localparam int RDPOS_W    = $clog2(RD_LEN + 1);
  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [1:0] {CLS_BYTE, CLS_WORD, CLS_BLOCK, CLS_RSVD} xfer_cls_e;
  typedef enum logic [1:0] {OP_RD_DW, OP_WR_B, OP_WR_W, OP_WR_DW} op_e;
  typedef enum logic [1:0] {TX_CNT, TX_DATA, TX_PEC, TX_PAD} tx_sel_e;

  typedef struct packed {
    logic    crcClr;
    logic    crcUpd;
    logic    crcFromTx;
    logic    workClr;
    logic    workLoad;
    logic    fieldWr;
    logic    commit;
    logic    launch;
    logic    rdRewind;
    logic    rdAdvance;
    logic    rspLoad;
    tx_sel_e txSel;
  } strobe_t;

  function automatic logic [7:0] crc8Step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/smbseq_datapath.sv
module smbseq_datapath
  import smbseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     st,
  input  logic [7:0]  rxByte,
  input  logic [7:0]  statusByte,
  input  logic [1:0]  cmdOp,
  input  logic        cmdMem,
  input  logic [31:0] rspData,
  output logic [7:0]  txByte,
  output logic        crcOk,
  output logic        rdPosZero,
  output logic [1:0]  reqOp,
  output logic        reqMem,
  output logic [31:0] reqAddr,
  output logic [31:0] reqData
);
  logic [FIELD_CNT-1:0][7:0] workF, keepF;
  logic [POS_W-1:0]          workPos, keepPos;
  logic [7:0]                crc;
  logic [RDPOS_W-1:0]        rdPos;
  logic [8*DATA_BYTES-1:0]   rdData;
  logic [31:0]               rawAddr, alignAddr;
  logic [7:0]                dataLane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workF <= '0; keepF <= '0; workPos <= '0; keepPos <= '0;
    end else begin
      if (st.workClr) begin
        workF <= '0; workPos <= '0;
      end else if (st.workLoad) begin
        workF <= keepF; workPos <= keepPos;
      end else if (st.fieldWr && workPos < POS_W'(FIELD_CNT)) begin
        workF[workPos[IDX_W-1:0]] <= rxByte;
        workPos <= workPos + 1'b1;
      end
      if (st.commit) begin
        keepF <= workF; keepPos <= workPos;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crc <= '0;
    else if (st.crcUpd) crc <= crc8Step(st.crcClr ? 8'h00 : crc, st.crcFromTx ? txByte : rxByte);
  end
  assign crcOk = (crc == 8'h00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPos <= '0;
    else if (st.rdRewind) rdPos <= '0;
    else if (st.rdAdvance && rdPos < RDPOS_W'(RD_LEN)) rdPos <= rdPos + 1'b1;
  end
  assign rdPosZero = (rdPos == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (st.rspLoad) rdData <= rspData;
  end

  always_comb begin
    if (cmdMem) rawAddr = {workF[0], workF[1], workF[2], workF[3]};
    else        rawAddr = {4'h0, workF[0], workF[1], workF[2][3:0], workF[3]};
    alignAddr = rawAddr;
    case (op_e'(cmdOp))
      OP_WR_W:            alignAddr[0]   = 1'b0;
      OP_WR_DW, OP_RD_DW: alignAddr[1:0] = 2'b00;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr <= '0; reqData <= '0; reqOp <= '0; reqMem <= 1'b0;
    end else if (st.launch) begin
      reqAddr <= alignAddr;
      reqData <= {workF[7], workF[6], workF[5], workF[4]};
      reqOp   <= cmdOp;
      reqMem  <= cmdMem;
    end
  end

  always_comb begin
    dataLane = 8'hFF;
    if (rdPos == '0) dataLane = statusByte;
    for (int i = 0; i < DATA_BYTES; i++)
      if (rdPos == RDPOS_W'(i + 1)) dataLane = rdData[8*i +: 8];
  end

  always_comb begin
    case (st.txSel)
      TX_CNT:  txByte = 8'(RD_LEN) - 8'(rdPos);
      TX_DATA: txByte = dataLane;
      TX_PEC:  txByte = crc;
      default: txByte = 8'hFF;
    endcase
  end

  a_r2_pos_bound: assert property (@(posedge clk) disable iff (!rstN)
    workPos <= POS_W'(FIELD_CNT) && keepPos <= POS_W'(FIELD_CNT));
  a_r9_rdpos_bound: assert property (@(posedge clk) disable iff (!rstN)
    rdPos <= RDPOS_W'(RD_LEN));
  a_r8_keep_only_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(keepF) && $stable(keepPos));
endmodule

// File: rtl/smbseq_ctrl.sv
module smbseq_ctrl
  import smbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxAddr,
  input  logic [7:0] rxByte,
  input  logic       rxStop,
  input  logic       txReq,
  input  logic [7:0] txByte,
  input  logic       crcOk,
  input  logic       rdPosZero,
  input  logic       reqReady,
  input  logic       rspValid,
  output strobe_t    st,
  output logic       reqValid,
  output logic [1:0] cmdOp,
  output logic       cmdMem,
  output logic [7:0] statusByte
);
  typedef enum logic [1:0] {S_IDLE, S_CMD, S_WPAY, S_RPH} state_e;
  state_e     state;
  logic [7:0] cmd, payIdx, cnt;
  logic       errFlag, busy, pendRead, badTx;
  xfer_cls_e  cls;
  logic       pecEn, isEnd, isData, goodW, errSet, errClr;
  logic [8:0] payLen, expLen, idx9;
  tx_sel_e    txSel;

  assign cls    = xfer_cls_e'(cmd[1:0]);
  assign pecEn  = cmd[4];
  assign isEnd  = cmd[6];
  assign cmdOp  = cmd[3:2];
  assign cmdMem = cmd[5];
  assign idx9   = {1'b0, payIdx};
  assign statusByte = {6'b0, busy, errFlag};

  always_comb begin
    case (cls)
      CLS_BYTE: payLen = 9'd1;
      CLS_WORD: payLen = 9'd2;
      default:  payLen = {1'b0, cnt} + 9'd1;
    endcase
    expLen = payLen + {8'b0, pecEn};
    isData = !(cls == CLS_BLOCK && payIdx == 8'd0) && idx9 < payLen;
    if (cls == CLS_BLOCK && payIdx == 8'd0) txSel = TX_CNT;
    else if (idx9 < payLen)                  txSel = TX_DATA;
    else if (idx9 == payLen && pecEn)        txSel = TX_PEC;
    else                                     txSel = TX_PAD;
    goodW = cls != CLS_RSVD && !badTx && idx9 == expLen && (!pecEn || crcOk);
  end

  always_comb begin
    st = '0;
    st.txSel = txSel;
    st.rspLoad = rspValid && busy && pendRead;
    case (state)
      S_IDLE: if (rxValid && rxAddr && !rxByte[0]) begin
        st.crcClr = 1'b1; st.crcUpd = 1'b1;
      end
      S_CMD: if (rxValid && !rxAddr) begin
        st.crcUpd = 1'b1;
        if (rxByte[7]) st.workClr = 1'b1;
        else           st.workLoad = 1'b1;
      end
      S_WPAY: begin
        if (rxValid) begin
          st.crcUpd = 1'b1;
          if (rxAddr) st.rdRewind = rxByte[0] && payIdx == 8'd0 && cmd[7];
          else        st.fieldWr = isData;
        end
        if (rxStop && goodW) begin
          st.commit = 1'b1;
          st.launch = isEnd && !busy;
        end
      end
      S_RPH: if (txReq) begin
        st.crcUpd = 1'b1; st.crcFromTx = 1'b1;
        st.rdAdvance = (txSel == TX_DATA);
      end
      default: ;
    endcase
  end

  assign errSet = rxStop && ((state == S_CMD) ||
                  (state == S_WPAY && (!goodW || (isEnd && busy))) ||
                  (state == S_RPH && cls == CLS_RSVD));
  assign errClr = state == S_RPH && txReq && txSel == TX_DATA && rdPosZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; cmd <= '0; payIdx <= '0; cnt <= '0; badTx <= 1'b0;
    end else if (rxStop) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (rxValid && rxAddr && !rxByte[0]) state <= S_CMD;
        S_CMD: if (rxValid && !rxAddr) begin
          cmd <= rxByte; payIdx <= '0; badTx <= 1'b0; state <= S_WPAY;
        end
        S_WPAY: if (rxValid) begin
          if (rxAddr) begin
            if (rxByte[0] && payIdx == 8'd0) state <= S_RPH;
            else badTx <= 1'b1;
          end else begin
            if (cls == CLS_BLOCK && payIdx == 8'd0) cnt <= rxByte;
            if (payIdx != 8'hFF) payIdx <= payIdx + 1'b1;
          end
        end
        S_RPH: if (txReq) begin
          if (txSel == TX_CNT) cnt <= txByte;
          if (payIdx != 8'hFF) payIdx <= payIdx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0; busy <= 1'b0; pendRead <= 1'b0; errFlag <= 1'b0;
    end else begin
      if (st.launch) begin
        reqValid <= 1'b1; busy <= 1'b1; pendRead <= (op_e'(cmd[3:2]) == OP_RD_DW);
      end else begin
        if (reqReady) reqValid <= 1'b0;
        if (rspValid) busy <= 1'b0;
      end
      if (errSet)      errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;
    end
  end

  a_r3_launch_at_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(rxStop));
  a_r10_req_implies_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy);
  a_r7_no_launch_reserved: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(cmd[1:0]) != 2'b11);
endmodule

// File: rtl/smbseq_top.sv
module smbseq_top
  import smbseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxAddr,
  input  logic [7:0]  rxByte,
  input  logic        rxStop,
  input  logic        txReq,
  output logic [7:0]  txByte,
  output logic        reqValid,
  input  logic        reqReady,
  output logic        reqWrite,
  output logic        reqMem,
  output logic [1:0]  reqOp,
  output logic [31:0] reqAddr,
  output logic [31:0] reqData,
  input  logic        rspValid,
  input  logic [31:0] rspData
);
  strobe_t    st;
  logic       crcOk, rdPosZero, cmdMem;
  logic [1:0] cmdOp;
  logic [7:0] statusByte;

  smbseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxAddr(rxAddr), .rxByte(rxByte),
    .rxStop(rxStop), .txReq(txReq), .txByte(txByte), .crcOk(crcOk),
    .rdPosZero(rdPosZero), .reqReady(reqReady), .rspValid(rspValid), .st(st),
    .reqValid(reqValid), .cmdOp(cmdOp), .cmdMem(cmdMem), .statusByte(statusByte)
  );

  smbseq_datapath dp_i (
    .clk(clk), .rstN(rstN), .st(st), .rxByte(rxByte), .statusByte(statusByte),
    .cmdOp(cmdOp), .cmdMem(cmdMem), .rspData(rspData), .txByte(txByte),
    .crcOk(crcOk), .rdPosZero(rdPosZero), .reqOp(reqOp), .reqMem(reqMem),
    .reqAddr(reqAddr), .reqData(reqData)
  );

  assign reqWrite = (reqOp != 2'b00);

  a_r5_word_align: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqOp == 2'b10 |-> !reqAddr[0]);
  a_r5_dword_align: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (reqOp == 2'b11 || reqOp == 2'b00) |-> reqAddr[1:0] == 2'b00);
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqData) && $stable(reqOp));
endmodule

// File: tb/smbseq_top_tb_top.sv
`timescale 1ns/1ps
module smbseq_top_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic rxValid = 0, rxAddr = 0, rxStop = 0, txReq = 0, reqReady = 0, rspValid = 0;
  logic [7:0] rxByte = '0;
  logic [31:0] rspData = '0;
  logic [7:0] txByte;
  logic reqValid, reqWrite, reqMem;
  logic [1:0] reqOp;
  logic [31:0] reqAddr, reqData;

  int total = 0, fails = 0, launches = 0;
  logic respEn = 1'b1;
  logic [31:0] retData = '0, capAddr, capData;
  logic [1:0] capOp;
  logic capMem, capWrite;
  logic [7:0] pay [16];
  logic [7:0] got [16];
  logic [7:0] tbCrc;

  always #10 clk = ~clk;

  smbseq_top dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxAddr(rxAddr), .rxByte(rxByte),
    .rxStop(rxStop), .txReq(txReq), .txByte(txByte), .reqValid(reqValid),
    .reqReady(reqReady), .reqWrite(reqWrite), .reqMem(reqMem), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid), .rspData(rspData)
  );

  function automatic logic [7:0] refCrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    logic fb;
    x = c;
    for (int i = 7; i >= 0; i--) begin
      fb = x[7] ^ d[i];
      x = {x[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic putB(input logic [7:0] b, input logic isA);
    @(negedge clk); rxValid = 1; rxAddr = isA; rxByte = b;
    tbCrc = refCrc(tbCrc, b);
    @(negedge clk); rxValid = 0; rxAddr = 0;
  endtask

  task automatic endTx();
    @(negedge clk); rxStop = 1;
    @(negedge clk); rxStop = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic wrTx(input logic [7:0] cmd, input int n, input logic badPec);
    tbCrc = 8'h00;
    putB(8'hB4, 1'b1);
    putB(cmd, 1'b0);
    for (int i = 0; i < n; i++) putB(pay[i], 1'b0);
    if (cmd[4]) putB(tbCrc ^ {7'b0, badPec}, 1'b0);
    endTx();
  endtask

  task automatic rdTx(input logic [7:0] cmd, input int n);
    tbCrc = 8'h00;
    putB(8'hB4, 1'b1);
    putB(cmd, 1'b0);
    putB(8'hB5, 1'b1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); got[i] = txByte; txReq = 1;
      @(negedge clk); txReq = 0;
    end
    endTx();
  endtask

  task automatic readStatus(output logic [7:0] s);
    rdTx(8'hC0, 1);
    s = got[0];
  endtask

  initial begin
    forever begin
      @(negedge clk);
      rspValid = 0;
      if (reqValid && respEn) begin
        capAddr = reqAddr; capData = reqData; capOp = reqOp;
        capMem = reqMem; capWrite = reqWrite; launches++;
        reqReady = 1;
        @(negedge clk); reqReady = 0; rspValid = 1; rspData = retData;
      end
    end
  end

  task automatic tReset();
    chk("R3 reset reqValid", {31'b0, reqValid}, 32'd0);
    chk("R3 reset launches", launches, 0);
  endtask

  task automatic tBlockWrite();
    int l0;
    l0 = launches;
    pay[0] = 8; pay[1] = 8'h12; pay[2] = 8'h34; pay[3] = 8'h05; pay[4] = 8'h6C;
    pay[5] = 8'h11; pay[6] = 8'h22; pay[7] = 8'h33; pay[8] = 8'h44;
    wrTx(8'hDE, 9, 1'b0);
    chk("R3 block write launched", launches - l0, 1);
    chk("R4 cfg address", capAddr, 32'h0123456C);
    chk("R2 write data order", capData, 32'h44332211);
    chk("R1 op dword", {30'b0, capOp}, 32'd3);
    chk("R1 cfg space", {31'b0, capMem}, 32'd0);
    chk("R4 write flag", {31'b0, capWrite}, 32'd1);
  endtask

  task automatic tSplitWrite();
    int l0;
    l0 = launches;
    pay[0] = 8'hAB; pay[1] = 8'hCD;
    wrTx(8'h8D, 2, 1'b0);
    pay[0] = 8'h0F; pay[1] = 8'hF0;
    wrTx(8'h0D, 2, 1'b0);
    chk("R3 no launch without End", launches - l0, 0);
    pay[0] = 4; pay[1] = 8'hDE; pay[2] = 8'hAD; pay[3] = 8'hBE; pay[4] = 8'hEF;
    wrTx(8'h4E, 5, 1'b0);
    chk("R2 split launch", launches - l0, 1);
    chk("R2 split address", capAddr, 32'h0ABCDFF0);
    chk("R2 split data", capData, 32'hEFBEADDE);
  endtask

  task automatic tAlign();
    pay[0] = 6; pay[1] = 8'h80; pay[2] = 8'h00; pay[3] = 8'h10; pay[4] = 8'h07;
    pay[5] = 8'h5A; pay[6] = 8'hA5;
    wrTx(8'hEA, 7, 1'b0);
    chk("R5 word align", capAddr, 32'h80001006);
    chk("R4 mem space", {31'b0, capMem}, 32'd1);
    chk("R1 Begin clears upper data", capData, 32'h0000A55A);
    pay[0] = 5; pay[1] = 8'h00; pay[2] = 8'h00; pay[3] = 8'h00; pay[4] = 8'h03; pay[5] = 8'h77;
    wrTx(8'hE6, 6, 1'b0);
    chk("R5 byte keeps low bits", capAddr, 32'h00000003);
    chk("R1 op byte", {30'b0, capOp}, 32'd1);
  endtask

  task automatic tReadBlock();
    logic [7:0] c;
    retData = 32'hCAFEF00D;
    pay[0] = 4; pay[1] = 8'h01; pay[2] = 8'h02; pay[3] = 8'h03; pay[4] = 8'h04;
    wrTx(8'hD2, 5, 1'b0);
    chk("R4 read address", capAddr, 32'h00102304);
    chk("R4 read flag", {31'b0, capWrite}, 32'd0);
    rdTx(8'hD2, 7);
    chk("R9 count byte", got[0], 5);
    chk("R10 status idle", got[1], 8'h00);
    chk("R11 data byte0", got[2], 8'h0D);
    chk("R11 data byte1", got[3], 8'hF0);
    chk("R11 data byte2", got[4], 8'hFE);
    chk("R11 data byte3", got[5], 8'hCA);
    c = 8'h00;
    c = refCrc(c, 8'hB4); c = refCrc(c, 8'hD2); c = refCrc(c, 8'hB5);
    for (int i = 0; i < 6; i++) c = refCrc(c, got[i]);
    chk("R6 read PEC", got[6], c);
  endtask

  task automatic tReadSplit();
    rdTx(8'h80, 1);
    chk("R9 split status", got[0], 8'h00);
    rdTx(8'h00, 1);
    chk("R9 split byte0", got[0], 8'h0D);
    rdTx(8'h01, 2);
    chk("R9 split word", {got[1], got[0]}, 16'hFEF0);
    rdTx(8'h02, 2);
    chk("R9 remaining count", got[0], 1);
    chk("R9 last byte", got[1], 8'hCA);
    rdTx(8'h00, 1);
    chk("R9 past end pad", got[0], 8'hFF);
  endtask

  task automatic tBadPec();
    int l0;
    logic [7:0] s;
    l0 = launches;
    pay[0] = 8; pay[1] = 8'h12; pay[2] = 8'h34; pay[3] = 8'h05; pay[4] = 8'h6C;
    pay[5] = 8'h11; pay[6] = 8'h22; pay[7] = 8'h33; pay[8] = 8'h44;
    wrTx(8'hDE, 9, 1'b1);
    chk("R6 bad PEC no launch", launches - l0, 0);
    readStatus(s);
    chk("R10 error set", s, 8'h01);
    readStatus(s);
    chk("R10 error cleared by read", s, 8'h00);
  endtask

  task automatic tDiscardKeeps();
    logic [7:0] s;
    pay[0] = 8'h21; pay[1] = 8'h43;
    wrTx(8'h8D, 2, 1'b0);
    pay[0] = 8'h65; pay[1] = 8'h87;
    wrTx(8'h1D, 2, 1'b1);
    pay[0] = 6; pay[1] = 8'h09; pay[2] = 8'hA8;
    pay[3] = 8'h01; pay[4] = 8'h02; pay[5] = 8'h03; pay[6] = 8'h04;
    wrTx(8'h4E, 7, 1'b0);
    chk("R8 fields kept address", capAddr, 32'h021439A8);
    chk("R8 fields kept data", capData, 32'h04030201);
    readStatus(s);
    chk("R8 discard flagged", s, 8'h01);
  endtask

  task automatic tReserved();
    int l0;
    logic [7:0] s;
    l0 = launches;
    pay[0] = 1; pay[1] = 2; pay[2] = 3;
    wrTx(8'hCF, 3, 1'b0);
    chk("R7 reserved no launch", launches - l0, 0);
    readStatus(s);
    chk("R7 reserved error", s, 8'h01);
    pay[0] = 8'h55;
    wrTx(8'hCE, 1, 1'b0);
    chk("R7 short block no launch", launches - l0, 0);
    readStatus(s);
    chk("R7 short block error", s, 8'h01);
  endtask

  task automatic tBusy();
    int l0;
    logic [7:0] s;
    l0 = launches;
    respEn = 1'b0;
    pay[0] = 8; pay[1] = 8'h00; pay[2] = 8'h00; pay[3] = 8'h01; pay[4] = 8'h00;
    pay[5] = 8'h01; pay[6] = 8'h02; pay[7] = 8'h03; pay[8] = 8'h04;
    wrTx(8'hCE, 9, 1'b0);
    chk("R3 request held", {31'b0, reqValid}, 32'd1);
    readStatus(s);
    chk("R10 pending bit", s, 8'h02);
    wrTx(8'hCE, 9, 1'b0);
    respEn = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 single launch", launches - l0, 1);
    chk("R3 held request address", capAddr, 32'h00000100);
    readStatus(s);
    chk("R12 busy End flagged", s, 8'h01);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBlockWrite();
    tSplitWrite();
    tAlign();
    tReadBlock();
    tReadSplit();
    tBadPec();
    tDiscardKeeps();
    tReserved();
    tBusy();
    finishRun();
  end
endmodule